// File: doc/BRIEF.md
# Serial Flag Receiver with Frame Sync

This block sits beside a serial audio data stream and listens to a second serial line that carries one corrector-flag word per audio word. Each flag word is 24 bit samples long and is aligned to the data word strobe. Only one bit of the word matters here: the absolute-time sync bit, called F1 in this project. It sits at a fixed position counted from the rising edge of the word strobe. The block latches F1 and discards every other bit.

When audio mode and the redirect enable are both set, a sampled F1 of one arms a small state machine. The state machine starts the internal data clock at the next rising edge of the word strobe, which marks a left-channel sample. It has three states. IDLE moves to ARMED when F1 is sampled as one while enabled. ARMED moves to RUN on the next strobe rising edge and raises `frame_start` for that one cycle. Any state returns to IDLE when either enable is low. RUN otherwise holds, and further F1 bits have no effect. The serial inputs are sampled only in cycles where `bit_en` is high. `bit_en` is the one-cycle-per-bit strobe of the serial data clock.

Top module: `flag_sync_receiver`

## Requirements
- R1: A strobe rising edge is a bit sample (bit_en high) with word_strobe high where the previous bit sample had it low; the strobe is treated as high out of reset, so a strobe already high after reset gives no edge and no F1 capture.
- R2: The bit sampled at index F1_POS (default 0, the edge sample itself; indices count bit samples from the edge) is latched into f1_flag, visible one clock after that sample and held until the next capture.
- R3: Bits at every other index of the 24-sample word leave f1_flag unchanged and never arm the clock start.
- R4: An F1 of one arms the start only while audio_mode and redirect_en are both 1; with either at 0 it is still latched into f1_flag but dclk_run stays 0.
- R5: Once armed, the next strobe rising edge (not the edge that carried F1) makes dclk_run 1 one clock after that sample, with frame_start high for exactly that same single cycle.
- R6: dclk_run stays 1 until audio_mode or redirect_en goes to 0, then is 0 one clock later; it starts again only after a new F1 and a following edge.
- R7: F1 of one while dclk_run is 1 produces no new frame_start and does not stop the clock.
- R8: Synchronous active-low reset clears f1_flag, frame_start and dclk_run.
- R9: Inputs in cycles with bit_en low are ignored: no edge, no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe per serial bit sample |
| word_strobe | input | 1 | Audio word strobe, high for the left channel |
| flag_sdata | input | 1 | Serial flag word data |
| audio_mode | input | 1 | Audio mode active |
| redirect_en | input | 1 | Allows F1 to start the internal data clock |
| f1_flag | output | 1 | Latched F1 bit |
| frame_start | output | 1 | Single-cycle pulse when the data clock starts |
| dclk_run | output | 1 | Internal data clock enable |

## Verification
Every result is registered once behind the input sample. f1_flag, frame_start and dclk_run all change one clock after the bit_en cycle that causes them, and dclk_run falls one clock after an enable drops. The bench drives each input set on a falling edge, lets one rising edge pass, and compares all three outputs at the next falling edge against a spec-level model stepped with the same inputs. Directed phases add literal expectations at those same points.

// File: rtl/flag_rx_pkg.sv
package flag_rx_pkg;
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ARMED = 2'd1,
        FS_RUN   = 2'd2
    } sync_state_e;
endpackage

// File: rtl/flag_word_sampler.sv
module flag_word_sampler #(
    parameter int WORD_BITS = 24,
    parameter int F1_POS    = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic word_strobe,
    input  logic flag_sdata,
    output logic ws_edge,
    output logic f1_capture,
    output logic f1_flag
);
    localparam int CW = $clog2(WORD_BITS);
    localparam logic [CW-1:0] LAST_IDX = CW'(WORD_BITS - 1);
    localparam logic [CW-1:0] F1_IDX   = CW'(F1_POS);

    logic          ws_prev;
    logic [CW-1:0] cnt;
    logic          cnt_valid;
    logic          step_ok;

    always_comb begin
        ws_edge    = bit_en && word_strobe && !ws_prev;
        step_ok    = cnt_valid && (cnt < LAST_IDX);
        if (ws_edge) begin
            f1_capture = (F1_IDX == '0);
        end else begin
            f1_capture = bit_en && step_ok && ((cnt + CW'(1)) == F1_IDX);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev   <= 1'b1;
            cnt       <= '0;
            cnt_valid <= 1'b0;
            f1_flag   <= 1'b0;
        end else if (bit_en) begin
            ws_prev <= word_strobe;
            if (ws_edge) begin
                cnt       <= '0;
                cnt_valid <= 1'b1;
            end else if (step_ok) begin
                cnt <= cnt + CW'(1);
            end else begin
                cnt_valid <= 1'b0;
            end
            if (f1_capture) begin
                f1_flag <= flag_sdata;
            end
        end
    end

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |-> (cnt <= LAST_IDX));
    p_f1_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !f1_capture |=> $stable(f1_flag));
    p_f1_idle_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(f1_flag));
endmodule

// File: rtl/frame_sync_fsm.sv
module frame_sync_fsm
    import flag_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ws_edge,
    input  logic f1_hit,
    output logic frame_start,
    output logic dclk_run
);
    sync_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = FS_IDLE;
        end else begin
            unique case (state)
                FS_IDLE:  if (f1_hit)  state_nx = FS_ARMED;
                FS_ARMED: if (ws_edge) state_nx = FS_RUN;
                FS_RUN:   state_nx = FS_RUN;
                default:  state_nx = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) frame_start <= 1'b0;
        else        frame_start <= (state == FS_ARMED) && (state_nx == FS_RUN);
    end

    assign dclk_run = (state == FS_RUN);

    p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    p_start_with_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> dclk_run);
    p_run_rise_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_run) |-> frame_start);
    p_start_after_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(ws_edge));
    p_drop_on_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !dclk_run);
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_run && enable) |=> !frame_start);
endmodule

// File: rtl/flag_sync_receiver.sv
module flag_sync_receiver #(
    parameter int WORD_BITS = 24,
    parameter int F1_POS    = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic word_strobe,
    input  logic flag_sdata,
    input  logic audio_mode,
    input  logic redirect_en,
    output logic f1_flag,
    output logic frame_start,
    output logic dclk_run
);
    logic ws_edge;
    logic f1_capture;
    logic start_enable;
    logic f1_hit;

    assign start_enable = audio_mode && redirect_en;
    assign f1_hit       = f1_capture && flag_sdata;

    flag_word_sampler #(
        .WORD_BITS (WORD_BITS),
        .F1_POS    (F1_POS)
    ) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .word_strobe (word_strobe),
        .flag_sdata  (flag_sdata),
        .ws_edge     (ws_edge),
        .f1_capture  (f1_capture),
        .f1_flag     (f1_flag)
    );

    frame_sync_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (start_enable),
        .ws_edge     (ws_edge),
        .f1_hit      (f1_hit),
        .frame_start (frame_start),
        .dclk_run    (dclk_run)
    );

    p_arm_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !start_enable |=> !frame_start);
endmodule

// File: tb/flag_sync_receiver_tb.sv
`timescale 1ns/1ps
module flag_sync_receiver_tb;
    localparam int WB  = 24;
    localparam int F1P = 0;

    logic clk = 1'b0;
    logic rst_n, bit_en, word_strobe, flag_sdata, audio_mode, redirect_en;
    logic f1_flag, frame_start, dclk_run;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string cur_req = "R8";

    logic m_wsp, m_f1, m_fs;
    int   m_idx, m_st;

    always #2 clk = ~clk;

    flag_sync_receiver #(.WORD_BITS(WB), .F1_POS(F1P)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_strobe(word_strobe),
        .flag_sdata(flag_sdata), .audio_mode(audio_mode), .redirect_en(redirect_en),
        .f1_flag(f1_flag), .frame_start(frame_start), .dclk_run(dclk_run)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic model(logic be, logic ws, logic sd);
        logic edg, cap, en;
        if (!rst_n) begin
            m_wsp = 1'b1; m_idx = -1; m_f1 = 1'b0; m_fs = 1'b0; m_st = 0;
            return;
        end
        en  = audio_mode && redirect_en;
        edg = be && ws && !m_wsp;
        cap = 1'b0;
        if (be) begin
            m_wsp = ws;
            if (edg) m_idx = 0;
            else if (m_idx >= 0 && m_idx < WB - 1) m_idx++;
            else m_idx = -1;
            cap = (m_idx == F1P);
        end
        if (cap) m_f1 = sd;
        m_fs = 1'b0;
        if (!en) m_st = 0;
        else if (m_st == 0 && cap && sd) m_st = 1;
        else if (m_st == 1 && edg) begin m_st = 2; m_fs = 1'b1; end
    endtask

    task automatic tick(logic be, logic ws, logic sd);
        bit_en = be; word_strobe = ws; flag_sdata = sd;
        @(posedge clk);
        @(negedge clk);
        model(be, ws, sd);
        chk(cur_req, "f1_flag", f1_flag, m_f1);
        chk(cur_req, "frame_start", frame_start, m_fs);
        chk(cur_req, "dclk_run", dclk_run, (m_st == 2));
    endtask

    task automatic send_word(logic f1bit, bit gaps);
        for (int i = 0; i < WB; i++) begin
            tick(1'b1, (i < WB / 2), (i == F1P) ? f1bit : 1'($urandom % 2));
            if (gaps) begin
                int g = int'($urandom % 3);
                for (int k = 0; k < g; k++) tick(1'b0, (i < WB / 2), 1'($urandom % 2));
            end
        end
    endtask

    initial begin
        #(4ns * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; audio_mode = 1'b1; redirect_en = 1'b1;
        bit_en = 1'b0; word_strobe = 1'b0; flag_sdata = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, 1'b0);
        // R8: reset state
        chk("R8", "f1_flag", f1_flag, 1'b0);
        chk("R8", "frame_start", frame_start, 1'b0);
        chk("R8", "dclk_run", dclk_run, 1'b0);

        // R1: strobe high out of reset is not an edge
        cur_req = "R1";
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b1);
        chk("R1", "f1_flag", f1_flag, 1'b0);
        tick(1'b1, 1'b0, 1'b0);

        // R9: strobe rise without bit_en is ignored
        cur_req = "R9";
        tick(1'b0, 1'b1, 1'b1);
        chk("R9", "f1_flag", f1_flag, 1'b0);

        // R2: F1 at the edge sample is latched and arms
        cur_req = "R2";
        tick(1'b1, 1'b1, 1'b1);
        chk("R2", "f1_flag", f1_flag, 1'b1);
        for (int i = 1; i < WB; i++) tick(1'b1, (i < WB / 2), 1'b0);
        chk("R5", "dclk_run same-edge", dclk_run, 1'b0);

        // R5: start at the following edge
        cur_req = "R5";
        tick(1'b1, 1'b1, 1'b0);
        chk("R5", "frame_start", frame_start, 1'b1);
        chk("R5", "dclk_run", dclk_run, 1'b1);
        tick(1'b0, 1'b1, 1'b0);
        chk("R5", "frame_start one cycle", frame_start, 1'b0);

        // R7: F1 while running has no effect
        cur_req = "R7";
        for (int i = 1; i < WB; i++) tick(1'b1, (i < WB / 2), 1'b0);
        send_word(1'b1, 1'b0);
        send_word(1'b0, 1'b0);
        chk("R7", "dclk_run", dclk_run, 1'b1);

        // R6: disable stops the clock, no restart without F1
        cur_req = "R6";
        redirect_en = 1'b0;
        tick(1'b0, 1'b0, 1'b0);
        chk("R6", "dclk_run", dclk_run, 1'b0);
        redirect_en = 1'b1;
        send_word(1'b0, 1'b0);
        send_word(1'b0, 1'b0);
        chk("R6", "dclk_run", dclk_run, 1'b0);

        // R3: ones at other positions are ignored
        cur_req = "R3";
        for (int i = 0; i < WB; i++) tick(1'b1, (i < WB / 2), (i != F1P));
        chk("R3", "f1_flag", f1_flag, 1'b0);
        send_word(1'b0, 1'b0);
        chk("R3", "dclk_run", dclk_run, 1'b0);

        // R4: gating by audio_mode and redirect_en
        cur_req = "R4";
        audio_mode = 1'b0;
        send_word(1'b1, 1'b0);
        chk("R4", "f1_flag", f1_flag, 1'b1);
        audio_mode = 1'b1;
        send_word(1'b0, 1'b0);
        chk("R4", "dclk_run", dclk_run, 1'b0);
        redirect_en = 1'b0;
        send_word(1'b1, 1'b0);
        redirect_en = 1'b1;
        send_word(1'b0, 1'b0);
        chk("R4", "dclk_run", dclk_run, 1'b0);

        // random words, gaps and enable changes
        cur_req = "R5/R6 random";
        for (int w = 0; w < 80; w++) begin
            audio_mode  = ($urandom % 8) != 0;
            redirect_en = ($urandom % 8) != 0;
            send_word(($urandom % 3) == 0, 1'b1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule